// File: doc/BRIEF.md
# Polled Bus-Grant Unit Handshake

This block is the per-unit mastership logic on a shared parallel bus run by a central controller. The controller picks a unit by putting that unit's address on the address lines and pulling the active-low poll strobe low. A unit whose local logic has a transfer pending, and which sees its own address when the strobe falls, takes the bus. It does so by enabling a pull-down on the shared open-collector bus-seized line. The unit stays master until its local logic signals completion, or until the controller pulls the active-low release line.

Local transfer logic watches a master flag. It also watches a one-cycle end pulse that tells it to discard any in-progress transfer state whenever mastership ends. After a forced release the unit holds the seized line for a fixed number of clocks and then lets it go. It takes the bus again only on a fresh poll that names it. The asynchronous strobe and release lines pass through a synchronizer before any decision uses them. The address width is a parameter: 8 bits for small systems, 16 when the high address lines are present.

Top module: `bus_grant_unit`

## Requirements
- R1: After reset, `master_o`, `seize_pd_o` and `rel_pulse_o` are all 0.
- R2: The unit takes the bus when three things hold at the clock where the synchronized `poll_stb_n_i` is first seen low after being high: `bus_addr_i` equals `unit_addr_i` in all ADDR_W bits, `req_i` is 1, and the synchronized `release_n_i` is 1. `master_o` and `seize_pd_o` then go to 1 exactly SYNC_STAGES+1 clocks after the strobe input falls.
- R3: A poll whose address differs from `unit_addr_i` in any bit, in the low octet or the high octet, leaves `master_o` and `seize_pd_o` at 0.
- R4: A poll seen while `req_i` is 0 is ignored. Raising `req_i` later while the strobe stays low does not take the bus; only a new high-to-low strobe transition can.
- R5: While master, `done_i` = 1 at a clock edge clears `master_o` and `seize_pd_o` at that same edge.
- R6: While master, `release_n_i` = 0 clears `master_o` SYNC_STAGES+1 clocks after the release input falls. `seize_pd_o` stays 1 for exactly DROP_CYC further clocks and then goes to 0.
- R7: After a forced release, no poll takes the bus again until a new strobe falling edge addressing the unit arrives once the drain has ended. A strobe edge that falls during the drain is ignored.
- R8: `rel_pulse_o` is 1 for exactly one clock, in the first clock where `master_o` is 0 after any end of mastership.
- R9: If `done_i` and a synchronized release arrive at the same clock, the voluntary path wins: `seize_pd_o` drops at once, with no drain.
- R10: A poll that arrives while the synchronized release line is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unit_addr_i | input | ADDR_W | This unit's strapped bus address |
| bus_addr_i | input | ADDR_W | Poll address from the bus (low octet, plus high lines when ADDR_W is 16) |
| poll_stb_n_i | input | 1 | Active-low bus-request poll strobe, asynchronous |
| release_n_i | input | 1 | Active-low forced-release line from the controller, asynchronous |
| req_i | input | 1 | Local logic has a transfer pending |
| done_i | input | 1 | Local logic gives up the bus voluntarily |
| seize_pd_o | output | 1 | Pull-down enable for the open-collector bus-seized line |
| master_o | output | 1 | This unit is currently bus master |
| rel_pulse_o | output | 1 | One-cycle pulse telling local logic to clear its transfer state |

## Verification
The bench builds the unit with a 16-bit address, a two-flop synchronizer and a drain of three clocks. The 16-bit address lets it separate mismatches that occur only in the high octet from those that occur only in the low octet. The drain of three clocks is longer than the synchronizer, so a strobe edge can be made to land inside the drain. Directed cases and randomized polls check the exact cycle where the bus is taken and released, the one-clock end pulse, and the simultaneous done-and-release priority.

// File: rtl/bgu_pkg.sv
package bgu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MASTER = 2'd1,
        ST_DRAIN  = 2'd2
    } bgu_state_e;
endpackage

// File: rtl/bgu_sync.sv
module bgu_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= async_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/bgu_poll_detect.sv
module bgu_poll_detect #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_n_s,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              poll_hit
);
    logic stb_prev_q;
    logic stb_fall;
    logic addr_match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_prev_q <= 1'b1;
        else        stb_prev_q <= stb_n_s;
    end

    assign stb_fall   = stb_prev_q & ~stb_n_s;
    assign addr_match = (bus_addr == own_addr);
    assign poll_hit   = stb_fall & addr_match;

    // a hit is a single-cycle event per strobe edge
    assert_hit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        poll_hit |=> !poll_hit);
endmodule

// File: rtl/bus_grant_unit.sv
module bus_grant_unit
    import bgu_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DROP_CYC    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] unit_addr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              poll_stb_n_i,
    input  logic              release_n_i,
    input  logic              req_i,
    input  logic              done_i,
    output logic              seize_pd_o,
    output logic              master_o,
    output logic              rel_pulse_o
);
    localparam int CNT_W = (DROP_CYC > 1) ? $clog2(DROP_CYC) : 1;
    localparam logic [CNT_W-1:0] DRAIN_LOAD = CNT_W'(DROP_CYC - 1);

    typedef struct packed {
        bgu_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } bgu_regs_t;

    bgu_regs_t cur_q, nxt_d;

    logic [1:0] lines_s;
    logic       stb_n_s;
    logic       rel_n_s;
    logic       poll_hit;

    bgu_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({release_n_i, poll_stb_n_i}),
        .sync_o  (lines_s)
    );
    assign stb_n_s = lines_s[0];
    assign rel_n_s = lines_s[1];

    bgu_poll_detect #(.ADDR_W(ADDR_W)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_n_s  (stb_n_s),
        .bus_addr (bus_addr_i),
        .own_addr (unit_addr_i),
        .poll_hit (poll_hit)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.pulse = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (poll_hit && req_i && rel_n_s) nxt_d.st = ST_MASTER;
            end
            ST_MASTER: begin
                if (done_i) begin
                    nxt_d.st    = ST_IDLE;
                    nxt_d.pulse = 1'b1;
                end else if (!rel_n_s) begin
                    nxt_d.st    = ST_DRAIN;
                    nxt_d.cnt   = DRAIN_LOAD;
                    nxt_d.pulse = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (cur_q.cnt == '0) nxt_d.st  = ST_IDLE;
                else                 nxt_d.cnt = cur_q.cnt - 1'b1;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st    <= ST_IDLE;
            cur_q.cnt   <= '0;
            cur_q.pulse <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign master_o    = (cur_q.st == ST_MASTER);
    assign seize_pd_o  = (cur_q.st == ST_MASTER) || (cur_q.st == ST_DRAIN);
    assign rel_pulse_o = cur_q.pulse;

    // mastership only ever begins from an accepted poll
    assert_grant_from_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_o) |-> $past(poll_hit && req_i && rel_n_s));

    // voluntary completion frees the line at the next edge
    assert_done_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_o && done_i) |=> (!master_o && !seize_pd_o));

    // forced release keeps the pull-down while draining
    assert_release_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_o && !done_i && !rel_n_s) |=> (!master_o && seize_pd_o));

    // drain never turns back into mastership
    assert_no_reseize_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seize_pd_o && !master_o) |=> !master_o);

    // drain counter stays inside its window
    assert_drain_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_DRAIN) |-> (cur_q.cnt < CNT_W'(DROP_CYC)));

    // end-of-mastership pulse lasts one clock
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rel_pulse_o |=> !rel_pulse_o);

    // a pulse follows every fall of the master flag
    assert_pulse_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(master_o) |-> rel_pulse_o);
endmodule

// File: tb/bus_grant_unit_test.sv
module bus_grant_unit_test;
    localparam int AW   = 16;
    localparam int SYN  = 2;
    localparam int DROP = 3;
    localparam logic [AW-1:0] OWN = 16'hA35C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          stb_n = 1'b1;
    logic          rel_n = 1'b1;
    logic          req = 1'b0;
    logic          done = 1'b0;
    logic          seize_pd, master, rel_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bus_grant_unit #(.ADDR_W(AW), .SYNC_STAGES(SYN), .DROP_CYC(DROP)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .unit_addr_i  (OWN),
        .bus_addr_i   (bus_addr),
        .poll_stb_n_i (stb_n),
        .release_n_i  (rel_n),
        .req_i        (req),
        .done_i       (done),
        .seize_pd_o   (seize_pd),
        .master_o     (master),
        .rel_pulse_o  (rel_pulse)
    );

    function automatic bit exp_grant(logic [AW-1:0] a, bit r, bit rel_ok);
        return (a == OWN) && r && rel_ok;
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(bit act, bit exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic poll(logic [AW-1:0] a);
        bus_addr = a;
        stb_n = 1'b0;
        step(SYN + 1);
    endtask

    task automatic unpoll();
        stb_n = 1'b1;
        step(SYN + 1);
    endtask

    task automatic force_release_check(string tag);
        rel_n = 1'b0;
        step(SYN + 1);
        chk(master, 1'b0, {tag, " master cleared"});
        chk(seize_pd, 1'b1, {tag, " seize held in drain"});
        chk(rel_pulse, 1'b1, {tag, " end pulse"});
        step(DROP - 1);
        chk(seize_pd, 1'b1, {tag, " seize last drain clock"});
        step(1);
        chk(seize_pd, 1'b0, {tag, " seize dropped after drain"});
        rel_n = 1'b1;
        step(SYN + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        step(3);
        // R1 reset state
        chk(master, 1'b0, "R1 master");
        chk(seize_pd, 1'b0, "R1 seize");
        chk(rel_pulse, 1'b0, "R1 pulse");
        rst_n = 1'b1;
        step(2);

        // R2 exact grant timing
        req = 1'b1;
        bus_addr = OWN;
        stb_n = 1'b0;
        step(SYN);
        chk(master, 1'b0, "R2 not yet master");
        step(1);
        chk(master, 1'b1, "R2 master");
        chk(seize_pd, 1'b1, "R2 seize");
        unpoll();
        // R5 voluntary done
        done = 1'b1;
        step(1);
        done = 1'b0;
        chk(master, 1'b0, "R5 master cleared");
        chk(seize_pd, 1'b0, "R5 seize cleared");
        chk(rel_pulse, 1'b1, "R8 pulse after done");
        step(1);
        chk(rel_pulse, 1'b0, "R8 pulse one clock");

        // R3 mismatch in low and high octet
        poll(OWN ^ 16'h0001);
        chk(seize_pd, 1'b0, "R3 low octet mismatch");
        unpoll();
        poll(OWN ^ 16'h8000);
        chk(seize_pd, 1'b0, "R3 high octet mismatch");
        unpoll();

        // R4 no request at poll, later request with strobe held
        req = 1'b0;
        poll(OWN);
        chk(master, 1'b0, "R4 ignored without request");
        req = 1'b1;
        step(4);
        chk(master, 1'b0, "R4 held strobe no grant");
        unpoll();
        poll(OWN);
        chk(master, 1'b1, "R4 new edge grants");
        unpoll();

        // R6 forced release with drain
        force_release_check("R6");

        // R7 strobe falling inside drain is ignored, new poll works
        poll(OWN);
        chk(master, 1'b1, "R7 setup master");
        unpoll();
        rel_n = 1'b0;
        step(SYN + 1);
        chk(seize_pd, 1'b1, "R7 in drain");
        rel_n = 1'b1;
        bus_addr = OWN;
        stb_n = 1'b0;
        step(DROP + SYN + 2);
        chk(master, 1'b0, "R7 no reseize from drain edge");
        chk(seize_pd, 1'b0, "R7 line free");
        unpoll();
        poll(OWN);
        chk(master, 1'b1, "R7 fresh poll reseizes");
        unpoll();

        // R9 done and release together
        rel_n = 1'b0;
        step(SYN);
        done = 1'b1;
        step(1);
        done = 1'b0;
        chk(master, 1'b0, "R9 master cleared");
        chk(seize_pd, 1'b0, "R9 no drain");
        chk(rel_pulse, 1'b1, "R9 pulse");

        // R10 poll while release held low
        poll(OWN);
        chk(master, 1'b0, "R10 poll during release");
        unpoll();
        rel_n = 1'b1;
        step(SYN + 1);

        // random polls against computed expectation
        for (int i = 0; i < 60; i++) begin
            logic [AW-1:0] a;
            bit r, g;
            a = $urandom_range(0, 1) ? OWN : AW'($urandom);
            r = bit'($urandom_range(0, 1));
            req = r;
            g = exp_grant(a, r, 1'b1);
            poll(a);
            chk(master, g, "R2 random poll master");
            chk(seize_pd, g, "R3 random poll seize");
            unpoll();
            if (g) begin
                if ($urandom_range(0, 1) == 0) begin
                    done = 1'b1;
                    step(1);
                    done = 1'b0;
                    chk(seize_pd, 1'b0, "R5 random done");
                    chk(rel_pulse, 1'b1, "R8 random pulse");
                    step(1);
                end else begin
                    force_release_check("R6 random");
                end
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule